// File: doc/BRIEF.md
# Dual-Channel Host Register Bus Decoder

This block sits between a host processor bus and two independent serial channels, A and B. The host presents an active-low chip select, a channel select line, a 3-bit register address, active-low read and write strobes and an 8-bit write data bus. The block brings the strobes into its clock domain and turns each new strobe into a one-cycle pulse aimed at one channel. It also latches the address and write data for the channels to use, and it multiplexes the read data of the addressed channel back to the host. The two channels have nothing in common except this bus front end and the clock.

A broadcast control input comes from a configuration bit that lives elsewhere. While it is set, every write goes to both channels in the same cycle, so the host can program identical settings into both register sets at once. Reads are never broadcast. A read always returns the data of the channel that the channel select line picks. The host bus has a tri-state read path. Here it is modelled as a read-data value plus an output-enable flag.

Top module: `dualChanBusDecoder`

## Requirements
- R1: While reset is held, and right after it, all four strobe pulses and the read output enable are low, and the latched address, latched write data and read data output are all zero.
- R2: When a write strobe (wrN) goes low, it is first sampled low at some rising edge. At the second rising edge after that one, one write pulse is issued if chipSelN is low at that edge. The pulse goes to channel A when chanSel is 1 and to channel B when chanSel is 0. chipSelN, chanSel, regAddr and wrData are all sampled at that same edge.
- R3: Each write or read strobe gives exactly one pulse, one clock cycle wide, however long the strobe is held low.
- R4: A strobe edge that meets a high chipSelN gives no pulse on either channel and does not turn on the read output.
- R5: When broadcastOn is 1 at the pulse edge, a write pulses wrPulseA and wrPulseB together in the same cycle, whatever the value of chanSel.
- R6: A read follows the timing of R2 but produces rdPulseA (chanSel 1) or rdPulseB (chanSel 0), never both, even when broadcastOn is 1.
- R7: regAddrOut and wrDataOut take regAddr and wrData at the edge of every accepted access, read or write. They hold those values through strobes that are ignored.
- R8: rdDataOe rises in the same cycle as the read pulse. It falls at the second rising edge after rdN is first sampled high again. While it is high, rdDataOut follows the live data of the channel the read picked. While it is low, rdDataOut is zero.
- R9: If write and read strobes become active at the same edge, the write is carried out and the read is dropped: no read pulse, and the output enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chipSelN | input | 1 | Host chip select, active low |
| chanSel | input | 1 | Channel choice: 1 selects A, 0 selects B |
| regAddr | input | 3 | Register address from the host |
| wrN | input | 1 | Host write strobe, active low, asynchronous |
| rdN | input | 1 | Host read strobe, active low, asynchronous |
| wrData | input | 8 | Host write data |
| broadcastOn | input | 1 | Configuration bit that sends writes to both channels |
| rdDataA | input | 8 | Read data presented by channel A |
| rdDataB | input | 8 | Read data presented by channel B |
| wrPulseA | output | 1 | One-cycle write strobe to channel A |
| wrPulseB | output | 1 | One-cycle write strobe to channel B |
| rdPulseA | output | 1 | One-cycle read strobe to channel A |
| rdPulseB | output | 1 | One-cycle read strobe to channel B |
| regAddrOut | output | 3 | Latched register address shared by both channels |
| wrDataOut | output | 8 | Latched write data shared by both channels |
| rdDataOut | output | 8 | Read data returned to the host |
| rdDataOe | output | 1 | Drive enable for the host read data |

## Verification
Take the edge at which a strobe is first sampled active. All four pulses, the latched address and data, and the rise of the output enable appear at the second rising edge after it. The output enable falls at the second edge after the strobe is first sampled inactive. The read data output depends combinationally on the channel data and changes as soon as those inputs change. The bench model keeps a short history of sampled strobe levels, so every expected value falls at the right edge. Outputs are compared one nanosecond after each rising edge, when the registers have settled and the inputs, which change only on falling edges, are stable. Per-operation pulse counts confirm the single-pulse, gating, broadcast and collision rules.

// File: rtl/busDecPkg.sv
package busDecPkg;

  // Strobes handed from the control path to the datapath each cycle.
  typedef struct packed {
    logic wrA;        // registered write pulse, channel A
    logic wrB;        // registered write pulse, channel B
    logic rdA;        // registered read pulse, channel A
    logic rdB;        // registered read pulse, channel B
    logic capture;    // combinational: latch address/data at this edge
    logic readOn;     // registered: a read is in progress
    logic readFromA;  // registered: the read in progress targets channel A
  } busStrobes_t;

endpackage

// File: rtl/strobeSync.sv
// Brings an asynchronous active-high level into the clock domain through
// a chain of flops. Reset value is the inactive level.
module strobeSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic levelIn,
  output logic levelOut
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : gStage
      if (i == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= levelIn;
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign levelOut = chain[STAGES-1];

endmodule

// File: rtl/busCtrl.sv
// Control path: synchronises the strobes, finds their leading edges,
// qualifies them with chip select and routes them to a channel.
module busCtrl
  import busDecPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        chipSelN,
  input  logic        chanSel,
  input  logic        broadcastOn,
  input  logic        wrN,
  input  logic        rdN,
  output busStrobes_t strobes
);

  logic wrLvl, rdLvl;
  logic wrPrev, rdPrev;
  logic wrRise, rdRise;
  logic wrHit, rdHit;
  logic csActive;
  logic toA, toB;

  strobeSync #(.STAGES(SYNC_STAGES)) uWrSync (
    .clk(clk), .rstN(rstN), .levelIn(~wrN), .levelOut(wrLvl)
  );
  strobeSync #(.STAGES(SYNC_STAGES)) uRdSync (
    .clk(clk), .rstN(rstN), .levelIn(~rdN), .levelOut(rdLvl)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev <= 1'b0;
      rdPrev <= 1'b0;
    end else begin
      wrPrev <= wrLvl;
      rdPrev <= rdLvl;
    end
  end

  always_comb begin
    csActive = ~chipSelN;
    wrRise   = wrLvl & ~wrPrev;
    rdRise   = rdLvl & ~rdPrev;
    wrHit    = wrRise & csActive;
    // A write arriving on the same edge takes precedence over a read.
    rdHit    = rdRise & csActive & ~wrHit;
    toA      = chanSel;
    toB      = ~chanSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobes.wrA       <= 1'b0;
      strobes.wrB       <= 1'b0;
      strobes.rdA       <= 1'b0;
      strobes.rdB       <= 1'b0;
      strobes.readOn    <= 1'b0;
      strobes.readFromA <= 1'b0;
    end else begin
      strobes.wrA <= wrHit & (toA | broadcastOn);
      strobes.wrB <= wrHit & (toB | broadcastOn);
      strobes.rdA <= rdHit & toA;
      strobes.rdB <= rdHit & toB;
      if (rdHit) begin
        strobes.readOn    <= 1'b1;
        strobes.readFromA <= toA;
      end else if (!rdLvl) begin
        strobes.readOn    <= 1'b0;
      end
    end
  end

  assign strobes.capture = wrHit | rdHit;

endmodule

// File: rtl/busDatapath.sv
// Datapath: address and write-data latches, read-data multiplexer.
module busDatapath
  import busDecPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       strobes,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] rdDataA,
  input  logic [DATA_W-1:0] rdDataB,
  output logic [ADDR_W-1:0] regAddrOut,
  output logic [DATA_W-1:0] wrDataOut,
  output logic [DATA_W-1:0] rdDataOut,
  output logic              rdDataOe
);

  localparam logic [DATA_W-1:0] IDLE_DATA = '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regAddrOut <= '0;
      wrDataOut  <= '0;
    end else if (strobes.capture) begin
      regAddrOut <= regAddr;
      wrDataOut  <= wrData;
    end
  end

  always_comb begin
    rdDataOe = strobes.readOn;
    if (!strobes.readOn)        rdDataOut = IDLE_DATA;
    else if (strobes.readFromA) rdDataOut = rdDataA;
    else                        rdDataOut = rdDataB;
  end

endmodule

// File: rtl/dualChanBusDecoder.sv
module dualChanBusDecoder
  import busDecPkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSelN,
  input  logic              chanSel,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrN,
  input  logic              rdN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              broadcastOn,
  input  logic [DATA_W-1:0] rdDataA,
  input  logic [DATA_W-1:0] rdDataB,
  output logic              wrPulseA,
  output logic              wrPulseB,
  output logic              rdPulseA,
  output logic              rdPulseB,
  output logic [ADDR_W-1:0] regAddrOut,
  output logic [DATA_W-1:0] wrDataOut,
  output logic [DATA_W-1:0] rdDataOut,
  output logic              rdDataOe
);

  busStrobes_t strobes;

  busCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .chanSel(chanSel),
    .broadcastOn(broadcastOn), .wrN(wrN), .rdN(rdN), .strobes(strobes)
  );

  busDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regAddr(regAddr),
    .wrData(wrData), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .regAddrOut(regAddrOut), .wrDataOut(wrDataOut),
    .rdDataOut(rdDataOut), .rdDataOe(rdDataOe)
  );

  assign wrPulseA = strobes.wrA;
  assign wrPulseB = strobes.wrB;
  assign rdPulseA = strobes.rdA;
  assign rdPulseB = strobes.rdB;

endmodule

// File: rtl/busDecoderChecker.sv
module busDecoderChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              chipSelN,
  input logic              broadcastOn,
  input logic              wrPulseA,
  input logic              wrPulseB,
  input logic              rdPulseA,
  input logic              rdPulseB,
  input logic              rdDataOe,
  input logic [DATA_W-1:0] rdDataOut
);

  assert_wr_a_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrPulseA |=> !wrPulseA);
  assert_wr_b_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrPulseB |=> !wrPulseB);
  assert_cs_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrPulseA || wrPulseB || rdPulseA || rdPulseB) |-> $past(!chipSelN));
  assert_dual_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrPulseA && wrPulseB) |-> $past(broadcastOn));
  assert_read_one_chan_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(rdPulseA && rdPulseB));
  assert_read_enables_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdPulseA || rdPulseB) |-> rdDataOe);
  assert_idle_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rdDataOe |-> (rdDataOut == '0));
  assert_wr_rd_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !((wrPulseA || wrPulseB) && (rdPulseA || rdPulseB)));

endmodule

bind dualChanBusDecoder busDecoderChecker #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .broadcastOn(broadcastOn),
  .wrPulseA(wrPulseA), .wrPulseB(wrPulseB), .rdPulseA(rdPulseA),
  .rdPulseB(rdPulseB), .rdDataOe(rdDataOe), .rdDataOut(rdDataOut)
);

// File: tb/sim_dualChanBusDecoder.sv
`timescale 1ns/1ps
module sim_dualChanBusDecoder;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chipSelN = 1'b1, chanSel = 1'b0, wrN = 1'b1, rdN = 1'b1;
  logic       broadcastOn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] wrData = '0, rdDataA = 8'hA5, rdDataB = 8'h5B;
  logic       wrPulseA, wrPulseB, rdPulseA, rdPulseB, rdDataOe;
  logic [2:0] regAddrOut;
  logic [7:0] wrDataOut, rdDataOut;

  int checks = 0, errors = 0;
  int nWrA = 0, nWrB = 0, nRdA = 0, nRdB = 0, nOe = 0;

  always #2 clk = ~clk;  // 250 MHz

  dualChanBusDecoder u0 (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .chanSel(chanSel),
    .regAddr(regAddr), .wrN(wrN), .rdN(rdN), .wrData(wrData),
    .broadcastOn(broadcastOn), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .wrPulseA(wrPulseA), .wrPulseB(wrPulseB), .rdPulseA(rdPulseA),
    .rdPulseB(rdPulseB), .regAddrOut(regAddrOut), .wrDataOut(wrDataOut),
    .rdDataOut(rdDataOut), .rdDataOe(rdDataOe)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: history of sampled strobe levels, newest first.
  bit w0, w1, w2, w3, r0, r1, r2, r3;
  bit eWA, eWB, eRA, eRB, eOn, eFromA;
  logic [2:0] eAddr;
  logic [7:0] eData, eRd;

  always @(posedge clk) begin
    bit wHit, rHit;
    if (!rstN) begin
      {w0, w1, w2, w3, r0, r1, r2, r3} = '0;
      {eWA, eWB, eRA, eRB, eOn, eFromA} = '0;
      eAddr = '0; eData = '0;
    end else begin
      w3 = w2; w2 = w1; w1 = w0; w0 = !wrN;
      r3 = r2; r2 = r1; r1 = r0; r0 = !rdN;
      wHit = w2 && !w3 && !chipSelN;
      rHit = r2 && !r3 && !chipSelN && !wHit;
      eWA = wHit && (chanSel || broadcastOn);
      eWB = wHit && (!chanSel || broadcastOn);
      eRA = rHit && chanSel;
      eRB = rHit && !chanSel;
      if (wHit || rHit) begin eAddr = regAddr; eData = wrData; end
      if (rHit) begin eOn = 1; eFromA = chanSel; end
      else if (!r2) eOn = 0;
    end
    #1;
    eRd = !eOn ? 8'h00 : (eFromA ? rdDataA : rdDataB);
    check("R2 wrPulseA", wrPulseA, eWA);
    check("R2 wrPulseB", wrPulseB, eWB);
    check("R6 rdPulseA", rdPulseA, eRA);
    check("R6 rdPulseB", rdPulseB, eRB);
    check("R7 regAddrOut", regAddrOut, eAddr);
    check("R7 wrDataOut", wrDataOut, eData);
    check("R8 rdDataOe", rdDataOe, eOn);
    check("R8 rdDataOut", rdDataOut, eRd);
    nWrA += wrPulseA; nWrB += wrPulseB;
    nRdA += rdPulseA; nRdB += rdPulseB; nOe += rdDataOe;
  end

  task automatic access(input bit csLow, input bit sel, input bit bc,
                        input bit doWr, input bit doRd, input logic [2:0] a,
                        input logic [7:0] d, input int hold);
    @(negedge clk);
    nWrA = 0; nWrB = 0; nRdA = 0; nRdB = 0; nOe = 0;
    chipSelN = !csLow; chanSel = sel; broadcastOn = bc;
    regAddr = a; wrData = d;
    wrN = !doWr; rdN = !doRd;
    repeat (hold) @(negedge clk);
    wrN = 1; rdN = 1;
    repeat (4) @(negedge clk);
    chipSelN = 1; broadcastOn = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1 strobes in reset", {wrPulseA, wrPulseB, rdPulseA, rdPulseB, rdDataOe}, 0);
    check("R1 latches in reset", {regAddrOut, wrDataOut, rdDataOut}, 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    check("R1 strobes after reset", {wrPulseA, wrPulseB, rdPulseA, rdPulseB, rdDataOe}, 0);

    access(1, 1, 0, 1, 0, 3'd2, 8'h11, 2);   // write A
    check("R2 write A count", {nWrA, nWrB}, {32'd1, 32'd0});
    access(1, 0, 0, 1, 0, 3'd5, 8'h22, 1);   // write B, short strobe
    check("R2 write B count", {nWrA, nWrB}, {32'd0, 32'd1});
    access(1, 1, 0, 1, 0, 3'd7, 8'h33, 12);  // long strobe
    check("R3 long write single pulse", nWrA, 1);
    access(1, 0, 0, 0, 1, 3'd1, 8'h00, 9);   // long read B
    check("R3 long read single pulse", {nRdA, nRdB}, {32'd0, 32'd1});

    access(0, 1, 0, 1, 0, 3'd4, 8'h44, 3);   // cs high write
    check("R4 cs high write ignored", nWrA + nWrB, 0);
    check("R7 address held after ignored write", regAddrOut, 3'd1);
    access(0, 1, 0, 0, 1, 3'd6, 8'h55, 3);   // cs high read
    check("R4 cs high read ignored", nRdA + nRdB + nOe, 0);

    access(1, 0, 1, 1, 0, 3'd3, 8'h66, 2);   // broadcast write
    check("R5 broadcast write both", {nWrA, nWrB}, {32'd1, 32'd1});
    access(1, 1, 1, 0, 1, 3'd0, 8'h00, 3);   // read during broadcast
    check("R6 read not broadcast", {nRdA, nRdB}, {32'd1, 32'd0});

    // R8: channel data changes while a read of B is open
    fork
      access(1, 0, 0, 0, 1, 3'd2, 8'h00, 8);
      begin
        repeat (5) @(negedge clk);
        rdDataB = 8'hC3;
        rdDataA = 8'h3C;
      end
    join
    check("R8 oe cycles for 8-cycle read", nOe, 8);

    access(1, 1, 0, 1, 1, 3'd6, 8'h77, 3);   // collision
    check("R9 write wins collision", nWrA, 1);
    check("R9 read dropped", nRdA + nRdB + nOe, 0);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule